// File: doc/BRIEF.md
# Frame-Aligned Master Clock Tick Divider

This block turns a master clock into a one-cycle tick enable at 256 kHz, i.e. 32 ticks for each 8 kHz frame. It also gives the index of each tick within the frame. A select input picks the divide ratio. A high select means 2.048 MHz operation and a divide by 8. A low select means the 1.536/1.544 MHz family and a divide by 6. The block samples the select only on a frame sync pulse, so a change takes effect at the next frame.

At 1.544 MHz a frame holds 193 master clocks. That is one more than 32 ticks of 6 cycles. The block measures the number of cycles between consecutive frame syncs. When that interval was exactly 193 and the slow family is selected, it stalls the divider for one cycle right after the sync. This keeps the 32 ticks uniformly spaced and aligned to the frame. After the 32nd tick of a frame the block stays silent until the next sync. Every sync restarts the tick index at 0.

Cycle numbering used below: the clock edge that samples `fsync` high is the sync edge, and cycle n is the n-th clock cycle after it.

Top module: `mclk_tick_divider`

## Requirements
- R1: From reset until the first sync, `tick` stays 0 and `tick_idx` reads 0.
- R2: Without compensation, cycle 1 after a sync carries `tick`=1 with `tick_idx`=0.
- R3: With `sel_fast`=1 at the sync, ticks fall on cycles 1+8k for k=0..31, with `tick_idx`=k. The last one is on cycle 249.
- R4: With `sel_fast`=0 at the sync, ticks fall on cycles 1+6k for k=0..31, with `tick_idx`=k. Two ticks are never on adjacent cycles.
- R5: With `sel_fast`=0, if the interval from the previous sync was exactly 193 cycles, cycle 1 carries no tick. Ticks then fall on cycles 2+6k.
- R6: A frame long enough carries exactly 32 ticks. `tick_idx` changes only on a tick or a sync.
- R7: `sel_fast` is sampled only on the sync edge. A change within a frame has no effect until the next sync.
- R8: No compensation is applied in the following cases: the interval was not 193, the fast mode is selected, or there was no earlier sync since reset.
- R9: A sync arriving at any point in a frame restarts the pattern at once from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_fast | input | 1 | 1: divide by 8 (2.048 MHz), 0: divide by 6 with 193-cycle compensation |
| fsync | input | 1 | Frame sync pulse, synchronous to clk |
| tick | output | 1 | One-cycle 256 kHz enable |
| tick_idx | output | 5 | Index of the tick within the frame |

## Verification
The assertions guard the following on every cycle:
- the tick or the stall cycle right after a sync;
- the index 0 tick right after a stall;
- silence before the first sync;
- the absence of adjacent ticks;
- the index and the mode staying put between their update events.

The exact tick positions, the count of 32 per frame, and the decision whether a frame gets the stall depend on the measured interval between syncs. Only the directed scenarios can show these. The scenarios run 192-, 193-, 256- and short frames, including mid-frame select changes.

// File: rtl/mclk_tick_divider.sv
module mclk_tick_divider #(
  parameter int DIV_FAST  = 8,
  parameter int DIV_SLOW  = 6,
  parameter int TICKS     = 32,
  parameter int ODD_FRAME = 193,
  parameter int IDX_W     = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fast,
  input  logic             fsync,
  output logic             tick,
  output logic [IDX_W-1:0] tick_idx
);
  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int PW   = $clog2(DMAX);
  localparam int CW   = $clog2(TICKS + 1);
  localparam int LW   = $clog2(DMAX * TICKS + 1) + 1;

  logic          fast_q, ref_q, hold_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] len_q;

  wire [PW-1:0] last_pre = fast_q ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  wire          odd_len  = ref_q && (len_q == LW'(ODD_FRAME));

  assign tick     = (pre_q == '0) && !hold_q && (cnt_q < CW'(TICKS));
  assign tick_idx = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q <= 1'b1;
      ref_q  <= 1'b0;
      hold_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= CW'(TICKS);
      len_q  <= '0;
    end else if (fsync) begin
      fast_q <= sel_fast;
      ref_q  <= 1'b1;
      hold_q <= !sel_fast && odd_len;
      pre_q  <= '0;
      cnt_q  <= '0;
      len_q  <= LW'(1);
    end else begin
      hold_q <= 1'b0;
      if (!hold_q) pre_q <= (pre_q == last_pre) ? '0 : pre_q + PW'(1);
      if (tick) cnt_q <= cnt_q + CW'(1);
      if (len_q != '1) len_q <= len_q + LW'(1);
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_q |-> !tick);
  p_sync_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (hold_q || (tick && tick_idx == '0)));
  p_no_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fsync) |=> !tick);
  p_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !fsync) |=> (tick && tick_idx == '0));
  p_idx_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fsync) |=> $stable(tick_idx));
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> $stable(fast_q));
endmodule

// File: tb/mclk_tick_divider_test.sv
module mclk_tick_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, sel_i = 1'b1, fs_i = 1'b0;
  logic tick;
  logic [4:0] idx;
  int total = 0, bad = 0, prev_p = 0;
  bit have_prev = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  mclk_tick_divider uut (.clk(clk), .rst_n(rst_n), .sel_fast(sel_i), .fsync(fs_i),
                         .tick(tick), .tick_idx(idx));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit sel, input int p, input string req, input int flip_at);
    bit hold;
    int d, j, seen, off;
    string r;
    hold = !sel && have_prev && prev_p == 193;
    off  = hold ? 1 : 0;
    d    = sel ? 8 : 6;
    seen = 0;
    @(negedge clk); fs_i = 1'b1; sel_i = sel;
    for (int k = 1; k < p; k++) begin
      @(negedge clk); fs_i = 1'b0;
      if (k == flip_at) sel_i = !sel;
      r = (k == 1) ? (hold ? "R5" : "R2") : req;
      j = k - 1 - off;
      if (tick) seen++;
      if (j >= 0 && j % d == 0 && j / d < 32) begin
        check(tick == 1'b1, r, $sformatf("tick at cycle %0d", k), int'(tick), 1);
        check(idx == 5'(j / d), r, $sformatf("index at cycle %0d", k), int'(idx), j / d);
      end else begin
        check(tick == 1'b0, r, $sformatf("no tick at cycle %0d", k), int'(tick), 0);
      end
    end
    if (p - 1 >= off + 1 + d * 31) check(seen == 32, "R6", "ticks per frame", seen, 32);
    prev_p = p;
    have_prev = 1'b1;
  endtask

  task automatic reset_r1();
    rst_n = 1'b0; fs_i = 1'b0; sel_i = 1'b1; have_prev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 10) sel_i = 1'b0;
      check(tick == 1'b0, "R1", "tick before first sync", int'(tick), 0);
      check(idx == 5'd0, "R1", "index before first sync", int'(idx), 0);
    end
  endtask

  task automatic test_r3_fast();
    run_frame(1'b1, 256, "R3", 0);
    run_frame(1'b1, 256, "R3", 0);
  endtask

  task automatic test_r4_slow();
    run_frame(1'b0, 192, "R4", 0);
    run_frame(1'b0, 192, "R4", 0);
  endtask

  task automatic test_r5_odd();
    run_frame(1'b0, 193, "R8", 0);
    run_frame(1'b0, 193, "R5", 0);
    run_frame(1'b0, 193, "R5", 0);
  endtask

  task automatic test_r8_no_hold();
    run_frame(1'b1, 256, "R8", 0);
    run_frame(1'b0, 193, "R8", 0);
    run_frame(1'b0, 192, "R5", 0);
  endtask

  task automatic test_r7_sel_mid();
    run_frame(1'b0, 192, "R7", 50);
    run_frame(1'b1, 256, "R7", 100);
  endtask

  task automatic test_r9_realign();
    run_frame(1'b1, 100, "R9", 0);
    run_frame(1'b0, 70, "R9", 0);
    run_frame(1'b1, 256, "R9", 0);
  endtask

  initial begin
    reset_r1();
    run_frame(1'b0, 193, "R8", 0);
    test_r3_fast();
    test_r4_slow();
    test_r5_odd();
    test_r8_no_hold();
    test_r7_sel_mid();
    test_r9_realign();
    reset_r1();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule